// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block keeps the bookkeeping for a circular queue of operation descriptors that software fills and a processing engine drains. Software never hands over raw pointers: it writes a count of newly prepared descriptors to a post register and, once it has consumed results, a count of finished descriptors to a release register. The block turns these counts into a fetch index walked around the ring, a number of posted-but-unfetched descriptors, and a number of completed-but-unreleased descriptors.

Towards the engine it offers a valid/ready fetch request carrying the ring index to load next, and it takes back one completion pulse per finished descriptor. A single read-only status word reports both the unreleased completion count and the ring index of the oldest unreleased descriptor. A one-cycle interrupt pulse is raised when the completion backlog reaches a programmable threshold. The ring depth is programmable and is capped by the selected descriptor format.

Top module: `desc_ring_ctrl`

## Requirements
- R1: After reset the block is halted, both counts and both pointers are zero, the format is the large one (read back as code 7), the programmed size reads 2^IDX_W, fetch_valid and irq_pulse are low.
- R2: The fetch index steps by one per accepted fetch and returns to 0 after reaching the effective size minus one; a programmed size of 0 acts as 1, a size above 2^IDX_W is stored as 2^IDX_W, and writing the size register zeroes the fetch and release pointers.
- R3: Writing format code 1 selects small descriptors with a ring limit of 2^IDX_W; code 7 selects large descriptors with a limit of 2^(IDX_W-2); the effective size is the smaller of programmed size and limit; a valid code write zeroes both pointers and any other code is ignored.
- R4: A write of N to the post register (address 2) adds N to the posted count; fetch_valid is high only while the posted count is non-zero, each accepted fetch lowers it by one, so no more fetches are granted than were posted.
- R5: Writing 0 to the halt register (address 4) starts the block, any non-zero value halts it; while halted fetch_valid stays low.
- R6: Each cycle with done_pulse high raises the unreleased completion count by one.
- R7: A write of N to the release register (address 3) lowers the completion count by N and moves the release pointer forward by N modulo the effective size.
- R8: A release of more than the current completion count is clamped to that count and sets a sticky error flag (bit 0 of address 7); writing 1 to bit 0 of address 7 clears it.
- R9: The status word (address 6) carries the completion count in bits [14:0] and the release pointer starting at bit 16 (bits [16+IDX_W-1:16]); all other bits read zero.
- R10: With a non-zero threshold (address 5), irq_pulse is a one-cycle pulse issued when the completion count first reaches or passes the threshold; it re-arms only after a release leaves the count below the threshold; threshold 0 disables it.
- R11: A post or release write, a completion pulse and an accepted fetch in the same cycle are all applied with the correct net effect on both counts and both pointers.
- R12: Register reads return the selected value one clock after reg_rd_addr is presented; address 7 bit 1 reads 1 while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write address |
| reg_wr_data | input | DATA_W | Register write data |
| reg_rd_addr | input | 3 | Register read address |
| reg_rd_data | output | DATA_W | Registered read data |
| fetch_valid | output | 1 | A descriptor is ready to be fetched |
| fetch_idx | output | IDX_W | Ring index of the descriptor to fetch |
| fetch_ready | input | 1 | Consumer accepts the fetch this cycle |
| done_pulse | input | 1 | One descriptor finished processing |
| irq_pulse | output | 1 | Completion threshold reached |

## Verification
The hardest situation to reach is a single cycle in which a post or release write, a completion pulse and a fetch handshake all land together, since each arrives through a different interface; the bench drives all three from one task on the same falling edge and then proves the net result by draining the ring and reading the status word. The interrupt re-arm rule is the other subtle path: the bench walks the backlog above the threshold, releases to just below it, raises it again, and also lowers the threshold under an existing backlog to provoke a fire without any completion. Pointer wrap is swept over every ring size of a 16-entry configuration in both formats.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
  localparam int REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] A_SIZE  = 3'd0;
  localparam logic [REG_ADDR_W-1:0] A_FMT   = 3'd1;
  localparam logic [REG_ADDR_W-1:0] A_POST  = 3'd2;
  localparam logic [REG_ADDR_W-1:0] A_REL   = 3'd3;
  localparam logic [REG_ADDR_W-1:0] A_HALT  = 3'd4;
  localparam logic [REG_ADDR_W-1:0] A_THR   = 3'd5;
  localparam logic [REG_ADDR_W-1:0] A_STAT  = 3'd6;
  localparam logic [REG_ADDR_W-1:0] A_FLAGS = 3'd7;

  localparam logic [3:0] FMT_CODE_SMALL = 4'd1;
  localparam logic [3:0] FMT_CODE_LARGE = 4'd7;

  localparam int STAT_PTR_LSB = 16;
endpackage

// File: rtl/desc_ring_regs.sv
module desc_ring_regs
  import desc_ring_pkg::*;
#(
  parameter int IDX_W  = 14,
  parameter int CNT_W  = 15,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [REG_ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  input  logic [DATA_W-1:0]     stat_word,
  input  logic                  err_flag,
  output logic [IDX_W:0]        size_eff,
  output logic                  run,
  output logic [CNT_W-1:0]      thr,
  output logic                  post_pulse,
  output logic                  rel_pulse,
  output logic [CNT_W-1:0]      cmd_n,
  output logic                  err_clr,
  output logic                  ptr_reset
);
  localparam logic [IDX_W:0] LIM_SMALL = {1'b1, {IDX_W{1'b0}}};
  localparam logic [IDX_W:0] LIM_LARGE = {3'b001, {(IDX_W-2){1'b0}}};

  logic [IDX_W:0]   size_q;
  logic             large_q;
  logic             halt_q;
  logic [CNT_W-1:0] thr_q;
  logic [DATA_W-1:0] rd_nx;
  logic [IDX_W:0]   size_clamped;

  logic hit_size, hit_fmt, hit_halt, hit_thr, hit_flags;
  logic code_small, code_large;

  assign hit_size  = wr_en && (wr_addr == A_SIZE);
  assign hit_fmt   = wr_en && (wr_addr == A_FMT);
  assign hit_halt  = wr_en && (wr_addr == A_HALT);
  assign hit_thr   = wr_en && (wr_addr == A_THR);
  assign hit_flags = wr_en && (wr_addr == A_FLAGS);

  assign post_pulse = wr_en && (wr_addr == A_POST);
  assign rel_pulse  = wr_en && (wr_addr == A_REL);
  assign cmd_n      = wr_data[CNT_W-1:0];

  assign code_small = (wr_data == DATA_W'(FMT_CODE_SMALL));
  assign code_large = (wr_data == DATA_W'(FMT_CODE_LARGE));

  assign ptr_reset = hit_size || (hit_fmt && (code_small || code_large));
  assign err_clr   = hit_flags && wr_data[0];

  always_comb begin
    if (wr_data == '0)
      size_clamped = {{IDX_W{1'b0}}, 1'b1};
    else if (wr_data > DATA_W'(LIM_SMALL))
      size_clamped = LIM_SMALL;
    else
      size_clamped = wr_data[IDX_W:0];
  end

  assign size_eff = (large_q && (size_q > LIM_LARGE)) ? LIM_LARGE : size_q;
  assign run      = !halt_q;
  assign thr      = thr_q;

  always_comb begin
    case (rd_addr)
      A_SIZE:  rd_nx = DATA_W'(size_q);
      A_FMT:   rd_nx = DATA_W'(large_q ? FMT_CODE_LARGE : FMT_CODE_SMALL);
      A_HALT:  rd_nx = DATA_W'(halt_q);
      A_THR:   rd_nx = DATA_W'(thr_q);
      A_STAT:  rd_nx = stat_word;
      A_FLAGS: rd_nx = DATA_W'({~halt_q, err_flag});
      default: rd_nx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q  <= LIM_SMALL;
      large_q <= 1'b1;
      halt_q  <= 1'b1;
      thr_q   <= '0;
      rd_data <= '0;
    end else begin
      rd_data <= rd_nx;
      if (hit_size) size_q <= size_clamped;
      if (hit_fmt && code_small) large_q <= 1'b0;
      if (hit_fmt && code_large) large_q <= 1'b1;
      if (hit_halt) halt_q <= (wr_data != '0);
      if (hit_thr) thr_q <= wr_data[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/desc_ring_track.sv
module desc_ring_track #(
  parameter int IDX_W = 14,
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W:0]   size_eff,
  input  logic             run,
  input  logic             ptr_reset,
  input  logic             post_pulse,
  input  logic             rel_pulse,
  input  logic [CNT_W-1:0] cmd_n,
  input  logic             err_clr,
  input  logic             done,
  input  logic             fetch_ready,
  output logic             fetch_valid,
  output logic [IDX_W-1:0] fetch_idx,
  output logic [CNT_W-1:0] posted,
  output logic [CNT_W-1:0] pend,
  output logic [CNT_W-1:0] pend_next,
  output logic [IDX_W-1:0] rel_ptr,
  output logic             err
);
  logic             take;
  logic [CNT_W:0]   post_sum;
  logic [CNT_W-1:0] posted_nx;
  logic [CNT_W-1:0] rel_eff;
  logic [CNT_W:0]   pend_sum;
  logic [CNT_W-1:0] rem;
  logic [IDX_W+1:0] rp_sum;
  logic [IDX_W+1:0] rp_wrap;
  logic [IDX_W:0]   fp_inc;
  logic [IDX_W-1:0] fetch_ptr;
  logic             over_rel;

  assign fetch_valid = run && (posted != '0);
  assign fetch_idx   = fetch_ptr;
  assign take        = fetch_valid && fetch_ready;

  // posted count: minus the accepted fetch, plus the post write, saturating
  assign post_sum  = {1'b0, posted - CNT_W'(take)} + (post_pulse ? {1'b0, cmd_n} : '0);
  assign posted_nx = post_sum[CNT_W] ? '1 : post_sum[CNT_W-1:0];

  // completion count: release clamped to the backlog, then the new completion
  assign over_rel  = rel_pulse && (cmd_n > pend);
  assign rel_eff   = rel_pulse ? (over_rel ? pend : cmd_n) : '0;
  assign pend_sum  = {1'b0, pend - rel_eff} + (CNT_W+1)'(done);
  assign pend_next = pend_sum[CNT_W] ? '1 : pend_sum[CNT_W-1:0];

  // release pointer moves by rel_eff modulo the ring size
  assign rem     = rel_eff % CNT_W'(size_eff);
  assign rp_sum  = (IDX_W+2)'(rel_ptr) + (IDX_W+2)'(rem);
  assign rp_wrap = (rp_sum >= (IDX_W+2)'(size_eff)) ? rp_sum - (IDX_W+2)'(size_eff) : rp_sum;

  assign fp_inc = (IDX_W+1)'(fetch_ptr) + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      posted    <= '0;
      pend      <= '0;
      fetch_ptr <= '0;
      rel_ptr   <= '0;
      err       <= 1'b0;
    end else begin
      posted <= posted_nx;
      pend   <= pend_next;
      if (over_rel) err <= 1'b1;
      else if (err_clr) err <= 1'b0;
      if (ptr_reset) begin
        fetch_ptr <= '0;
        rel_ptr   <= '0;
      end else begin
        if (take) fetch_ptr <= (fp_inc >= size_eff) ? '0 : fp_inc[IDX_W-1:0];
        if (rel_pulse) rel_ptr <= rp_wrap[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/desc_ring_irq.sv
module desc_ring_irq #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] pend_next,
  input  logic [CNT_W-1:0] thr,
  input  logic             rel_evt,
  output logic             irq
);
  logic armed;
  logic fire;

  assign fire = armed && (thr != '0) && (pend_next >= thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b1;
      irq   <= 1'b0;
    end else begin
      irq <= fire;
      if (fire) armed <= 1'b0;
      else if (rel_evt && (pend_next < thr)) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl
  import desc_ring_pkg::*;
#(
  parameter int IDX_W  = 14,
  parameter int CNT_W  = 15,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr_en,
  input  logic [REG_ADDR_W-1:0] reg_wr_addr,
  input  logic [DATA_W-1:0]     reg_wr_data,
  input  logic [REG_ADDR_W-1:0] reg_rd_addr,
  output logic [DATA_W-1:0]     reg_rd_data,
  output logic                  fetch_valid,
  output logic [IDX_W-1:0]      fetch_idx,
  input  logic                  fetch_ready,
  input  logic                  done_pulse,
  output logic                  irq_pulse
);
  logic [IDX_W:0]   size_eff;
  logic             run;
  logic [CNT_W-1:0] thr;
  logic             post_pulse;
  logic             rel_pulse;
  logic [CNT_W-1:0] cmd_n;
  logic             err_clr;
  logic             ptr_reset;
  logic [CNT_W-1:0] posted_cnt;
  logic [CNT_W-1:0] pend_cnt;
  logic [CNT_W-1:0] pend_next;
  logic [IDX_W-1:0] rel_ptr;
  logic             err;
  logic [DATA_W-1:0] stat_word;

  assign stat_word = DATA_W'(pend_cnt) | (DATA_W'(rel_ptr) << STAT_PTR_LSB);

  desc_ring_regs #(.IDX_W(IDX_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
    .stat_word(stat_word), .err_flag(err),
    .size_eff(size_eff), .run(run), .thr(thr),
    .post_pulse(post_pulse), .rel_pulse(rel_pulse), .cmd_n(cmd_n),
    .err_clr(err_clr), .ptr_reset(ptr_reset)
  );

  desc_ring_track #(.IDX_W(IDX_W), .CNT_W(CNT_W)) track_i (
    .clk(clk), .rst(rst),
    .size_eff(size_eff), .run(run), .ptr_reset(ptr_reset),
    .post_pulse(post_pulse), .rel_pulse(rel_pulse), .cmd_n(cmd_n),
    .err_clr(err_clr), .done(done_pulse), .fetch_ready(fetch_ready),
    .fetch_valid(fetch_valid), .fetch_idx(fetch_idx),
    .posted(posted_cnt), .pend(pend_cnt), .pend_next(pend_next),
    .rel_ptr(rel_ptr), .err(err)
  );

  desc_ring_irq #(.CNT_W(CNT_W)) irq_i (
    .clk(clk), .rst(rst),
    .pend_next(pend_next), .thr(thr), .rel_evt(rel_pulse),
    .irq(irq_pulse)
  );
endmodule

// File: rtl/desc_ring_chk.sv
module desc_ring_chk #(
  parameter int IDX_W = 14,
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             fetch_valid,
  input logic             fetch_ready,
  input logic [IDX_W-1:0] fetch_idx,
  input logic             irq_pulse,
  input logic [CNT_W-1:0] posted,
  input logic [CNT_W-1:0] pend,
  input logic [IDX_W:0]   size_eff,
  input logic             running,
  input logic             rel_pulse,
  input logic             done
);
  // R5: no fetch request while halted
  assert_fetch_needs_run_R5: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |-> running);

  // R4: no fetch request without posted work
  assert_fetch_needs_work_R4: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |-> (posted != '0));

  // R2: requested index always inside the effective ring
  assert_idx_in_ring_R2: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |-> ((IDX_W+1)'(fetch_idx) < size_eff));

  // R10: interrupt is a single-cycle pulse
  assert_irq_single_R10: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);

  // R6: a lone completion raises the backlog by exactly one
  assert_done_step_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !rel_pulse && (pend != '1)) |=> (pend == CNT_W'($past(pend) + 1'b1)));

  // R7: the backlog never drops without a release write
  assert_no_silent_drop_R7: assert property (@(posedge clk) disable iff (rst)
    !rel_pulse |=> (pend >= $past(pend)));
endmodule

bind desc_ring_ctrl desc_ring_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst),
  .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_idx(fetch_idx),
  .irq_pulse(irq_pulse), .posted(posted_cnt), .pend(pend_cnt),
  .size_eff(size_eff), .running(run), .rel_pulse(rel_pulse), .done(done_pulse)
);

// File: tb/desc_ring_ctrl_tb_top.sv
module desc_ring_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 4;
  localparam int CNT_W = 15;
  localparam int DATA_W = 32;
  localparam int LIM_S = 16;
  localparam int LIM_L = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0;
  logic [2:0] reg_wr_addr = '0;
  logic [DATA_W-1:0] reg_wr_data = '0;
  logic [2:0] reg_rd_addr = '0;
  logic [DATA_W-1:0] reg_rd_data;
  logic fetch_valid;
  logic [IDX_W-1:0] fetch_idx;
  logic fetch_ready = 1'b0;
  logic done_pulse = 1'b0;
  logic irq_pulse;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_ring_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .fetch_valid(fetch_valid), .fetch_idx(fetch_idx), .fetch_ready(fetch_ready),
    .done_pulse(done_pulse), .irq_pulse(irq_pulse)
  );

  int n_chk = 0, n_err = 0;
  int irq_cnt = 0, irq_dbl = 0;
  logic irq_prev = 1'b0;
  bit finished = 0;

  // model state
  int m_posted = 0, m_pend = 0, m_fptr = 0, m_rptr = 0;
  int m_prog = LIM_S, m_size = LIM_L, m_large = 1, m_thr = 0;
  int m_err = 0, m_run = 0, m_irq = 0, m_armed = 1;

  always @(negedge clk) begin
    if (rst) irq_prev <= 1'b0;
    else begin
      if (irq_pulse) irq_cnt++;
      if (irq_pulse && irq_prev) irq_dbl++;
      irq_prev <= irq_pulse;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    reg_wr_en = 1'b1; reg_wr_addr = a[2:0]; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    reg_rd_addr = a[2:0];
    @(negedge clk);
    d = reg_rd_data;
  endtask

  task automatic m_eval(bit rel);
    if (m_armed && m_thr != 0 && m_pend >= m_thr) begin
      m_irq++; m_armed = 0;
    end else if (rel && m_pend < m_thr) m_armed = 1;
  endtask

  task automatic m_resize();
    m_size = (m_large && m_prog > LIM_L) ? LIM_L : m_prog;
    m_fptr = 0; m_rptr = 0;
  endtask

  task automatic do_size(int v);
    wr(0, v);
    m_prog = (v == 0) ? 1 : ((v > LIM_S) ? LIM_S : v);
    m_resize();
  endtask

  task automatic do_fmt(int code);
    wr(1, code);
    if (code == 1) begin m_large = 0; m_resize(); end
    else if (code == 7) begin m_large = 1; m_resize(); end
  endtask

  task automatic do_post(int n);
    wr(2, n); m_posted += n;
  endtask

  task automatic do_take(int n, string tag);
    for (int i = 0; i < n; i++) begin
      chk({tag, " valid"}, fetch_valid, 1);
      chk({tag, " idx"}, fetch_idx, m_fptr);
      fetch_ready = 1'b1;
      @(negedge clk);
      fetch_ready = 1'b0;
      m_fptr = (m_fptr + 1) % m_size;
      m_posted--;
    end
  endtask

  task automatic do_done(int n);
    for (int i = 0; i < n; i++) begin
      done_pulse = 1'b1;
      @(negedge clk);
      done_pulse = 1'b0;
      m_pend++; m_eval(0);
    end
  endtask

  task automatic do_rel(int n);
    int eff;
    wr(3, n);
    eff = (n > m_pend) ? m_pend : n;
    if (n > m_pend) m_err = 1;
    m_pend -= eff;
    m_rptr = (m_rptr + eff) % m_size;
    m_eval(1);
  endtask

  task automatic do_thr(int v);
    wr(5, v); m_thr = v; m_eval(0);
  endtask

  task automatic chk_stat(string tag);
    int d;
    rd(6, d);
    chk(tag, d, m_pend | (m_rptr << 16));
  endtask

  task automatic chk_irq(string tag);
    idle(3);
    chk(tag, irq_cnt, m_irq);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 fetch_valid", fetch_valid, 0);
    chk("R1 irq", irq_pulse, 0);
    rd(6, d); chk("R1 status", d, 0);
    rd(7, d); chk("R1 flags", d, 0);
    rd(1, d); chk("R1 format code", d, 7);
    rd(0, d); chk("R1 size", d, LIM_S);

    // R3 small format, ring of 5, threshold 4
    do_fmt(1);
    do_size(5);
    do_thr(4);

    // R5 halted: posted work is not requested
    do_post(3);
    idle(2);
    chk("R5 halted no fetch", fetch_valid, 0);
    wr(4, 0); m_run = 1;
    rd(7, d); chk("R12 running flag", (d >> 1) & 1, 1);
    do_take(3, "R4 first batch");
    chk("R4 no overfetch", fetch_valid, 0);

    // R2 wrap at 5
    do_post(4);
    do_take(4, "R2 wrap");
    chk("R4 drained", fetch_valid, 0);

    // R5 non-zero halt value stops
    do_post(1);
    wr(4, 5); m_run = 0;
    idle(1);
    chk("R5 halt nonzero", fetch_valid, 0);
    wr(4, 0); m_run = 1;
    do_take(1, "R5 resume");

    // R6 completions, R10 first crossing
    do_done(6);
    chk_stat("R6 R9 status after 6 done");
    chk_irq("R10 one pulse at threshold");

    // R7 releases, R10 rearm
    do_rel(2);
    chk_stat("R7 release 2");
    chk_irq("R10 no pulse while disarmed");
    do_rel(1);
    chk_stat("R7 release 1");
    do_done(1);
    chk_irq("R10 rearmed pulse");

    // R8 over-release
    do_rel(10);
    chk_stat("R8 clamped release");
    rd(7, d); chk("R8 sticky error", d & 1, 1);
    wr(7, 1); m_err = 0;
    rd(7, d); chk("R8 error cleared", d & 1, 0);

    // R10 crossing by lowering the threshold
    do_done(3);
    chk_irq("R10 below threshold");
    do_thr(2);
    chk_irq("R10 fire on lowered threshold");
    do_rel(3);
    do_thr(0);
    do_done(3);
    chk_irq("R10 threshold zero disables");
    do_rel(3);
    chk_stat("R7 backlog emptied");

    // R3 large format caps ring at 4
    do_fmt(7);
    do_post(5);
    do_take(5, "R3 large cap");
    do_fmt(3);
    do_size(6);
    do_post(5);
    do_take(5, "R3 invalid code ignored");
    rd(1, d); chk("R3 code read back", d, 7);
    do_fmt(1);
    do_post(7);
    do_take(7, "R3 small ring 6");

    // R2 size 0 and oversize
    do_size(0);
    do_post(3);
    do_take(3, "R2 size zero");
    do_size(40);
    rd(0, d); chk("R2 size clamp read", d, LIM_S);
    do_post(17);
    do_take(17, "R2 oversize clamp");

    // R2 R3 sweep of every size in both formats
    for (int sz = 1; sz <= LIM_S; sz++) begin
      do_size(sz);
      do_post(sz + 1);
      do_take(sz + 1, "R2 sweep small");
      chk("R4 sweep drained", fetch_valid, 0);
    end
    do_fmt(7);
    for (int sz = 1; sz <= 6; sz++) begin
      do_size(sz);
      do_post(sz + 1);
      do_take(sz + 1, "R3 sweep large");
    end
    do_fmt(1);

    // R11 simultaneous events
    do_size(5);
    wr(4, 1); m_run = 0;
    do_post(3);
    wr(4, 0); m_run = 1;
    chk("R11 pre valid", fetch_valid, 1);
    chk("R11 pre idx", fetch_idx, m_fptr);
    reg_wr_en = 1'b1; reg_wr_addr = 3'd2; reg_wr_data = 2;
    done_pulse = 1'b1; fetch_ready = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; done_pulse = 1'b0; fetch_ready = 1'b0;
    m_posted += 1; m_fptr = (m_fptr + 1) % m_size; m_pend++; m_eval(0);
    do_take(4, "R11 net posted");
    chk("R11 posted exhausted", fetch_valid, 0);
    chk_stat("R11 pend after add+done");
    reg_wr_en = 1'b1; reg_wr_addr = 3'd3; reg_wr_data = 1;
    done_pulse = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; done_pulse = 1'b0;
    m_pend = m_pend - 1 + 1; m_rptr = (m_rptr + 1) % m_size; m_eval(1);
    chk_stat("R11 release+done same cycle");

    chk_irq("R10 final pulse count");
    chk("R10 no back-to-back pulses", irq_dbl, 0);

    summary();
    $finish;
  end
endmodule